// File: doc/BRIEF.md
# Quadrature Position Counter with Boundary Checks

This block keeps a signed position or event count from two count inputs and one auxiliary input. Each of the three raw inputs is first brought into the clock domain and then filtered. A filtered input changes level only after the raw input has held a new level for a number of clocks set by software. The two filtered count inputs are decoded in one of three ways: as a quadrature (gray-code) pair, as a count pulse plus a direction level, or as separate up and down pulses. Every accepted step moves the count by one and produces a one-cycle event strobe, which a separate timer can use to measure the time between steps.

The auxiliary input has two uses. With the marker function on, its rising edge clears the count. With the marker function off, it is a push-button and only sets a status flag. Two signed boundary registers are compared against the value that a step would produce. In warning mode, crossing a boundary sets a sticky flag that drives the interrupt. In auto-zero mode, crossing a boundary loads zero into the count instead.

A flat register port is used for setup and readback. It has write enable, address and data, and the read data is combinational. The register map is: 0 control (bit0 enable, bits2:1 decode mode, bit3 marker on, bit4 auto-zero), 1 filter length (bits4:0), 2 upper boundary, 3 lower boundary, 4 count (read and write), 5 status (write one to clear), 6 filtered input levels (bit0 A, bit1 B, bit2 auxiliary).

Top module: `qenc_counter`

## Requirements
- R1: After reset the count, the control register, the status register and irq are all zero, the upper boundary is 0x7FFFFFFF and the lower boundary is 0x80000000.
- R2: A filtered input takes a new raw level only after that level has held for max(L,1) consecutive clocks, where L is the filter length in bits4:0 of address 1. A shorter pulse is ignored and changes nothing.
- R3: In mode 0 (control bits2:1 = 0), the pair {A,B} is read as a gray code. Each move along 00→01→11→10→00 adds one, and each move in the reverse direction subtracts one.
- R4: In mode 0, a change of both A and B in the same filtered cycle sets status bit2 and leaves the count unchanged.
- R5: In mode 1, a rising edge of A counts. B low means up and B high means down. Changes of B alone do not count.
- R6: In mode 2, a rising edge of A alone adds one and a rising edge of B alone subtracts one.
- R7: With control bit3 set, a rising edge of the auxiliary input clears the count and sets status bit3. This takes priority over a step in the same cycle. With control bit3 clear, the rising edge sets status bit4 and leaves the count unchanged.
- R8: With control bit4 clear, a step whose result is signed-greater than the upper boundary sets status bit0, and a step whose result is signed-less than the lower boundary sets status bit1. In both cases the count takes the stepped value.
- R9: With control bit4 set, a step whose result would cross either boundary loads zero into the count and sets no boundary flag.
- R10: count_evt is high for exactly one clock for each accepted step. This includes a step that auto-zeroes the count.
- R11: Status bits stay set until software writes a one to that bit at address 5. irq is high whenever any status bit is set.
- R12: With control bit0 clear, no step changes the count and count_evt stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the filter sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_a | input | 1 | Raw count input A |
| in_b | input | 1 | Raw count input B |
| in_aux | input | 1 | Raw marker or push-button input |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | OR of all status flags |
| count_evt | output | 1 | One-cycle strobe per accepted step |

## Verification
The in-line properties check several things on every clock:
- a filtered level only ever moves to the value its synchronizer held one clock earlier;
- a set status flag survives unless its clear bit was written;
- every event strobe coincides with the count moving by one or landing on zero;
- a marker edge always leaves the count at zero.

The bench scenarios cover what the properties cannot see:
- the decoded direction in each of the three modes;
- the rejection of a pulse shorter than the filter length;
- the signed boundary thresholds and the choice between a warning and an auto-zero;
- a long random quadrature walk compared against a reference count.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_DIR  = 2'd1,
    MODE_STEP = 2'd2,
    MODE_OFF  = 2'd3
  } qmode_e;

  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_FILT   = 1;
  localparam int ADDR_UPPER  = 2;
  localparam int ADDR_LOWER  = 3;
  localparam int ADDR_COUNT  = 4;
  localparam int ADDR_STATUS = 5;
  localparam int ADDR_LEVELS = 6;

  localparam int FLG_W    = 5;
  localparam int FLG_UP   = 0;
  localparam int FLG_LO   = 1;
  localparam int FLG_ERR  = 2;
  localparam int FLG_MARK = 3;
  localparam int FLG_BTN  = 4;

  localparam int CTRL_W      = 5;
  localparam int CTRL_EN     = 0;
  localparam int CTRL_MODE_L = 1;
  localparam int CTRL_MK     = 3;
  localparam int CTRL_AZ     = 4;

endpackage

// File: rtl/qenc_debounce.sv
module qenc_debounce #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len,
  input  logic             raw,
  output logic             lvl
);

  localparam int RUN_W = LEN_W + 1;

  logic             sync1_q, sync2_q;
  logic             lvl_q, lvl_d;
  logic [LEN_W-1:0] run_q, run_d;
  logic [RUN_W-1:0] need;
  logic [RUN_W-1:0] run_next;

  always_comb begin
    need     = (len == '0) ? RUN_W'(1) : {1'b0, len};
    run_next = {1'b0, run_q} + RUN_W'(1);
    lvl_d    = lvl_q;
    run_d    = '0;
    if (sync2_q != lvl_q) begin
      if (run_next >= need) begin
        lvl_d = sync2_q;
        run_d = '0;
      end else begin
        run_d = run_next[LEN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      lvl_q   <= 1'b0;
      run_q   <= '0;
    end else begin
      sync1_q <= raw;
      sync2_q <= sync1_q;
      lvl_q   <= lvl_d;
      run_q   <= run_d;
    end
  end

  assign lvl = lvl_q;

  // R2: the filtered level only moves to what the synchronizer held
  p_accept_synced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> (lvl_q == $past(sync2_q)));

endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  qmode_e mode,
  input  logic   a,
  input  logic   b,
  output logic   step_up,
  output logic   step_dn,
  output logic   step_err
);

  logic       a_prev_q, b_prev_q;
  logic [1:0] pos_now, pos_old, pos_diff;
  logic       a_rise, b_rise;

  always_comb begin
    pos_now  = {a, a ^ b};
    pos_old  = {a_prev_q, a_prev_q ^ b_prev_q};
    pos_diff = pos_now - pos_old;
    a_rise   = a & ~a_prev_q;
    b_rise   = b & ~b_prev_q;
    step_up  = 1'b0;
    step_dn  = 1'b0;
    step_err = 1'b0;
    unique case (mode)
      MODE_QUAD: begin
        step_up  = (pos_diff == 2'd1);
        step_dn  = (pos_diff == 2'd3);
        step_err = (pos_diff == 2'd2);
      end
      MODE_DIR: begin
        step_up = a_rise & ~b;
        step_dn = a_rise & b;
      end
      MODE_STEP: begin
        step_up = a_rise & ~b_rise;
        step_dn = b_rise & ~a_rise;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev_q <= 1'b0;
      b_prev_q <= 1'b0;
    end else begin
      a_prev_q <= a;
      b_prev_q <= b;
    end
  end

  // R4: a double transition in quadrature mode flags and never steps
  p_double_is_error_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_QUAD && a != a_prev_q && b != b_prev_q)
      |-> (step_err && !step_up && !step_dn));

  // R3: at most one decode outcome per cycle
  p_single_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn, step_err}));

endmodule

// File: rtl/qenc_core.sv
module qenc_core
  import qenc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    autozero,
  input  logic                    mk_en,
  input  logic                    step_up,
  input  logic                    step_dn,
  input  logic                    step_err,
  input  logic                    aux_lvl,
  input  logic signed [CNT_W-1:0] upper,
  input  logic signed [CNT_W-1:0] lower,
  input  logic                    cnt_we,
  input  logic signed [CNT_W-1:0] cnt_wdata,
  input  logic [FLG_W-1:0]        clr_mask,
  output logic signed [CNT_W-1:0] cnt,
  output logic [FLG_W-1:0]        flags,
  output logic                    evt
);

  localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

  logic signed [CNT_W-1:0] cnt_q, cnt_d, cand;
  logic [FLG_W-1:0]        flg_q, flg_d;
  logic                    evt_q, evt_d;
  logic                    aux_prev_q;
  logic                    aux_rise, mk_fire, stepping, over, under;

  always_comb begin
    aux_rise = aux_lvl & ~aux_prev_q;
    mk_fire  = mk_en & aux_rise & ~cnt_we;
    stepping = en & (step_up | step_dn) & ~cnt_we & ~mk_fire;
    cand     = step_up ? (cnt_q + ONE) : (cnt_q - ONE);
    over     = (cand > upper);
    under    = (cand < lower);

    cnt_d = cnt_q;
    evt_d = 1'b0;
    flg_d = flg_q & ~clr_mask;

    if (cnt_we) begin
      cnt_d = cnt_wdata;
    end else if (mk_fire) begin
      cnt_d = '0;
    end else if (stepping) begin
      evt_d = 1'b1;
      cnt_d = ((over || under) && autozero) ? '0 : cand;
    end

    if (stepping && !autozero) begin
      if (over)  flg_d[FLG_UP] = 1'b1;
      if (under) flg_d[FLG_LO] = 1'b1;
    end
    if (en && step_err) flg_d[FLG_ERR] = 1'b1;
    if (aux_rise) begin
      if (mk_en) flg_d[FLG_MARK] = 1'b1;
      else       flg_d[FLG_BTN]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      flg_q      <= '0;
      evt_q      <= 1'b0;
      aux_prev_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      flg_q      <= flg_d;
      evt_q      <= evt_d;
      aux_prev_q <= aux_lvl;
    end
  end

  assign cnt   = cnt_q;
  assign flags = flg_q;
  assign evt   = evt_q;

  // R10: each strobe matches a one-step move or an auto-zero
  p_evt_moves_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_q |-> (cnt_q == $past(cnt_q) + ONE || cnt_q == $past(cnt_q) - ONE || cnt_q == '0));

  // R11: set flags persist unless cleared by a write
  p_flags_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flg_q) & ~$past(clr_mask)) & ~flg_q) == '0));

  // R7: a marker edge leaves the count at zero
  p_marker_zeroes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mk_fire |=> (cnt_q == '0));

  // R12: no strobe while disabled
  p_disabled_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !evt_q);

endmodule

// File: rtl/qenc_counter.sv
module qenc_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int LEN_W  = 5,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              in_aux,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              count_evt
);

  localparam int NUM_IN = 3;
  localparam logic [CNT_W-1:0] UPPER_RST = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] LOWER_RST = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [CNT_W-1:0]  upper_q, upper_d, lower_q, lower_d;
  logic [NUM_IN-1:0] raw, lvl;
  logic              wr_ctrl, wr_len, wr_upper, wr_lower, wr_cnt, wr_stat;
  logic [FLG_W-1:0]  clr_mask, flags;
  logic              step_up, step_dn, step_err;
  logic signed [CNT_W-1:0] cnt;
  qmode_e            mode;

  assign raw = {in_aux, in_b, in_a};

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_filt
    qenc_debounce #(.LEN_W(LEN_W)) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .len   (len_q),
      .raw   (raw[gi]),
      .lvl   (lvl[gi])
    );
  end

  always_comb begin
    wr_ctrl  = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL));
    wr_len   = reg_we && (reg_addr == ADDR_W'(ADDR_FILT));
    wr_upper = reg_we && (reg_addr == ADDR_W'(ADDR_UPPER));
    wr_lower = reg_we && (reg_addr == ADDR_W'(ADDR_LOWER));
    wr_cnt   = reg_we && (reg_addr == ADDR_W'(ADDR_COUNT));
    wr_stat  = reg_we && (reg_addr == ADDR_W'(ADDR_STATUS));
    ctrl_d   = wr_ctrl  ? reg_wdata[CTRL_W-1:0] : ctrl_q;
    len_d    = wr_len   ? reg_wdata[LEN_W-1:0]  : len_q;
    upper_d  = wr_upper ? reg_wdata : upper_q;
    lower_d  = wr_lower ? reg_wdata : lower_q;
    clr_mask = wr_stat  ? reg_wdata[FLG_W-1:0]  : '0;
    mode     = qmode_e'(ctrl_q[CTRL_MODE_L +: 2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      len_q   <= '0;
      upper_q <= UPPER_RST;
      lower_q <= LOWER_RST;
    end else begin
      ctrl_q  <= ctrl_d;
      len_q   <= len_d;
      upper_q <= upper_d;
      lower_q <= lower_d;
    end
  end

  qenc_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .a        (lvl[0]),
    .b        (lvl[1]),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .step_err (step_err)
  );

  qenc_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ctrl_q[CTRL_EN]),
    .autozero  (ctrl_q[CTRL_AZ]),
    .mk_en     (ctrl_q[CTRL_MK]),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .step_err  (step_err),
    .aux_lvl   (lvl[2]),
    .upper     ($signed(upper_q)),
    .lower     ($signed(lower_q)),
    .cnt_we    (wr_cnt),
    .cnt_wdata ($signed(reg_wdata)),
    .clr_mask  (clr_mask),
    .cnt       (cnt),
    .flags     (flags),
    .evt       (count_evt)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(ADDR_CTRL):   reg_rdata[CTRL_W-1:0] = ctrl_q;
      ADDR_W'(ADDR_FILT):   reg_rdata[LEN_W-1:0]  = len_q;
      ADDR_W'(ADDR_UPPER):  reg_rdata = upper_q;
      ADDR_W'(ADDR_LOWER):  reg_rdata = lower_q;
      ADDR_W'(ADDR_COUNT):  reg_rdata = cnt;
      ADDR_W'(ADDR_STATUS): reg_rdata[FLG_W-1:0]  = flags;
      ADDR_W'(ADDR_LEVELS): reg_rdata[NUM_IN-1:0] = lvl;
      default: ;
    endcase
  end

  assign irq = |flags;

  // R11: interrupt follows the flag set
  p_irq_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($countones(flags) != 0));

endmodule

// File: tb/qenc_counter_tb.sv
module qenc_counter_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_a, in_b, in_aux;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq, count_evt;

  int checks = 0;
  int failures = 0;
  int evt_n = 0;
  int flen = 3;

  always #2.5 clk = ~clk;

  qenc_counter u_dut (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_aux(in_aux),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .count_evt(count_evt)
  );

  always @(negedge clk) if (rst_n && count_evt) evt_n++;

  function automatic logic [31:0] model_step(input logic [31:0] c, input bit up,
      input logic [31:0] hi, input logic [31:0] lo, input bit az);
    logic signed [31:0] n;
    n = up ? $signed(c) + 1 : $signed(c) - 1;
    if (az && (n > $signed(hi) || n < $signed(lo))) return 32'd0;
    return n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(addr); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 3'(addr);
    #1 v = reg_rdata;
  endtask

  task automatic settle();
    repeat (flen + 6) @(negedge clk);
  endtask

  task automatic pulse_a();
    in_a = 1'b1; settle(); in_a = 1'b0; settle();
  endtask

  task automatic pulse_b();
    in_b = 1'b1; settle(); in_b = 1'b0; settle();
  endtask

  task automatic pulse_aux();
    in_aux = 1'b1; settle(); in_aux = 1'b0; settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v, exp_c;
    int ph, e0;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; in_a = 0; in_b = 0; in_aux = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(4, v); chk("R1 count", v, 0);
    rd(5, v); chk("R1 status", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd(2, v); chk("R1 upper", v, 32'h7FFF_FFFF);
    rd(3, v); chk("R1 lower", v, 32'h8000_0000);

    wr(1, flen);

    // R3 quadrature forward and reverse
    wr(0, 32'h1);
    ph = 0; exp_c = 0; e0 = evt_n;
    for (int i = 0; i < 4; i++) begin
      ph = (ph + 1) % 4; in_a = ph[1]; in_b = ph[1] ^ ph[0]; settle();
    end
    rd(4, v); chk("R3 forward", v, 4);
    for (int i = 0; i < 6; i++) begin
      ph = (ph + 3) % 4; in_a = ph[1]; in_b = ph[1] ^ ph[0]; settle();
    end
    rd(4, v); chk("R3 reverse", v, 32'hFFFF_FFFE);
    chk("R10 strobes", evt_n - e0, 10);

    // R3/R10 random walk against model
    wr(4, 0); exp_c = 0; e0 = evt_n;
    for (int i = 0; i < 60; i++) begin
      bit up;
      up = ($urandom % 2) == 1;
      ph = up ? (ph + 1) % 4 : (ph + 3) % 4;
      in_a = ph[1]; in_b = ph[1] ^ ph[0];
      exp_c = model_step(exp_c, up, 32'h7FFF_FFFF, 32'h8000_0000, 0);
      settle();
    end
    rd(4, v); chk("R3 random walk", v, exp_c);
    chk("R10 random strobes", evt_n - e0, 60);

    // R4 double transition
    rd(4, exp_c);
    ph = (ph + 2) % 4; in_a = ph[1]; in_b = ph[1] ^ ph[0]; settle();
    rd(4, v); chk("R4 count held", v, exp_c);
    rd(5, v); chk("R4 err flag", v, 32'h4);
    chk("R11 irq set", {31'd0, irq}, 1);
    repeat (5) @(negedge clk);
    rd(5, v); chk("R11 sticky", v, 32'h4);
    wr(5, 32'h4);
    rd(5, v); chk("R11 cleared", v, 0);
    chk("R11 irq low", {31'd0, irq}, 0);
    in_a = 0; in_b = 0; settle(); wr(5, 32'h1F);

    // R6 step mode
    wr(0, 32'h5); wr(4, 10);
    pulse_a(); pulse_a(); pulse_b();
    rd(4, v); chk("R6 step", v, 11);

    // R2 short glitch ignored with longer filter
    flen = 8; wr(1, 8);
    e0 = evt_n;
    in_a = 1; repeat (4) @(negedge clk); in_a = 0; settle();
    rd(4, v); chk("R2 glitch count", v, 11);
    rd(6, v); chk("R2 level", v, 0);
    chk("R2 no strobe", evt_n - e0, 0);
    pulse_a();
    rd(4, v); chk("R2 held accepted", v, 12);
    flen = 3; wr(1, 3);

    // R5 direction mode
    wr(0, 32'h3);
    in_b = 1; settle();
    pulse_a();
    rd(4, v); chk("R5 down", v, 11);
    in_b = 0; settle();
    pulse_a();
    rd(4, v); chk("R5 up", v, 12);

    // R12 disabled
    wr(0, 32'h4); e0 = evt_n;
    pulse_a();
    rd(4, v); chk("R12 count held", v, 12);
    chk("R12 no strobe", evt_n - e0, 0);

    // R8 warning boundaries
    wr(0, 32'h5); wr(2, 5); wr(3, 32'hFFFF_FFFD); wr(5, 32'h1F);
    wr(4, 4);
    pulse_a();
    rd(5, v); chk("R8 at upper no flag", v, 0);
    pulse_a();
    rd(4, v); chk("R8 upper count", v, 6);
    rd(5, v); chk("R8 upper flag", v, 32'h1);
    wr(5, 32'h1F);
    wr(4, 32'hFFFF_FFFD);
    pulse_b();
    rd(4, v); chk("R8 lower count", v, 32'hFFFF_FFFC);
    rd(5, v); chk("R8 lower flag", v, 32'h2);
    wr(5, 32'h1F);

    // R9 auto-zero
    wr(0, 32'h15); wr(4, 5); e0 = evt_n;
    pulse_a();
    exp_c = model_step(5, 1, 5, 32'hFFFF_FFFD, 1);
    rd(4, v); chk("R9 upper zero", v, exp_c);
    rd(5, v); chk("R9 no flag", v, 0);
    chk("R10 autozero strobe", evt_n - e0, 1);
    wr(4, 32'hFFFF_FFFD);
    pulse_b();
    rd(4, v); chk("R9 lower zero", v, 0);

    // R7 marker and push-button
    wr(0, 32'h5); wr(4, 7);
    pulse_aux();
    rd(5, v); chk("R7 button flag", v, 32'h10);
    rd(4, v); chk("R7 button count", v, 7);
    wr(5, 32'h1F);
    wr(0, 32'hD);
    pulse_aux();
    rd(4, v); chk("R7 marker zero", v, 0);
    rd(5, v); chk("R7 marker flag", v, 32'h8);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule